// File: doc/BRIEF.md
# Floating-Point Exception Status Register

This block holds the exception and mode state of a floating-point unit. When the arithmetic datapath finishes an operation, it presents five IEEE exception indications. The register then replaces its per-operation cause field with them and accumulates them into a sticky flag field. It raises a one-cycle trap request, carrying a fixed vector code, when any new cause bit lines up with a software enable bit.

Software can overwrite the whole register in one cycle, through a fixed mask of writable bits. That write also sets a rounding-mode field and a denormal flush control, and both are exported to the datapath as decoded, registered controls.

A reciprocal square-root approximation always reports an imprecise result. When the datapath marks an operation as that approximation and no other exception was raised, the inexact cause is forced on.

Top module: `fpx_status_reg`

## Requirements
- R1: After synchronous reset, `csr_q` is 0, `trap_req` is 0, `trap_vec` is 0, `rnd_to_zero` is 0 and `flush_den` is 0.
- R2: One cycle after `op_done` (without `sw_wr`), cause bits 16:12 equal the new cause. The mapping is invalid=`op_flags[4]`→16, divide-by-zero=`op_flags[3]`→15, overflow=`op_flags[2]`→14, underflow=`op_flags[1]`→13 and inexact=`op_flags[0]`→12. Cause bit 17 reads 0 after every operation.
- R3: On an operation, the new cause bits are ORed into flag bits 6:2, using the same order as the cause bits (invalid at bit 6, inexact at bit 2). An operation never clears a flag bit.
- R4: An operation leaves the enable bits 11:7 unchanged (invalid at bit 11, inexact at bit 7). It also leaves rounding bits 1:0 and bit 18 unchanged.
- R5: When the new cause ANDed with the enable field is nonzero, `trap_req` is high for exactly the cycle after `op_done`. `trap_vec` reads 0x120 during that cycle and 0 otherwise.
- R6: No trap is raised when the new cause and the enables do not overlap. This holds even if a sticky flag bit matches an enable.
- R7: With `op_rsqrt` set and `op_flags` zero, the cause is inexact only. With `op_rsqrt` set and any other flag raised, the cause equals `op_flags` unmodified.
- R8: `sw_wr` stores `sw_wdata & 0x0007FFFF` one cycle later. Bits 31:19 read 0.
- R9: After a write, `rnd_to_zero` is 1 when written bits 1:0 are 01, and 0 for 00, 10 or 11 (round to nearest even).
- R10: After a write, `flush_den` equals written bit 18.
- R11: When `sw_wr` and `op_done` occur in the same cycle, the write alone takes effect and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_done | input | 1 | Datapath operation completed this cycle |
| op_flags | input | 5 | Exception indications {invalid, divzero, overflow, underflow, inexact} |
| op_rsqrt | input | 1 | Completed operation was the reciprocal square-root approximation |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write value |
| csr_q | output | 32 | Current register contents |
| trap_req | output | 1 | One-cycle exception trap request |
| trap_vec | output | 12 | Trap vector code, valid with trap_req |
| rnd_to_zero | output | 1 | Datapath rounding: 1 toward zero, 0 nearest even |
| flush_den | output | 1 | Datapath denormal flush-to-zero enable |

## Verification
The bench uses the default parameters: a 32-bit register, five flags, writable mask 0x0007FFFF and vector 0x120. With these, writing all ones shows that bits 31:19 are masked off. The reserved cause bit 17 can be seeded by software and is seen to clear on the next operation. Each of the four rounding encodings can be written in turn. With five flags, single-flag and multi-flag patterns can be set against chosen enables, which reaches trap and non-trap outcomes. This includes a sticky bit that matches an enable while no new cause does.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NF       = 5;
  localparam int RM_LO    = 0;
  localparam int RM_W     = 2;
  localparam int FLAG_LO  = RM_LO + RM_W;
  localparam int FLAG_HI  = FLAG_LO + NF - 1;
  localparam int EN_LO    = FLAG_HI + 1;
  localparam int EN_HI    = EN_LO + NF - 1;
  localparam int CAUSE_LO = EN_HI + 1;
  localparam int CAUSE_HI = CAUSE_LO + NF;
  localparam int DN_BIT   = CAUSE_HI + 1;
  localparam int MIN_W    = DN_BIT + 1;

  typedef logic [NF-1:0] fpx_vec_t;
endpackage

// File: rtl/fpx_cause_gen.sv
module fpx_cause_gen
  import fpx_pkg::*;
(
  input  logic [NF-1:0] flags,
  input  logic          rsqrt,
  output logic [NF-1:0] cause
);
  logic others_raised;
  assign others_raised = |flags[NF-1:1];

  for (genvar i = 0; i < NF; i++) begin : g_map
    if (i == 0) begin : g_inexact
      assign cause[i] = flags[i] | (rsqrt & ~others_raised);
    end else begin : g_plain
      assign cause[i] = flags[i];
    end
  end
endmodule

// File: rtl/fpx_trap_unit.sv
module fpx_trap_unit
  import fpx_pkg::*;
#(
  parameter int              VEC_W    = 12,
  parameter logic [VEC_W-1:0] TRAP_VEC = 12'h120
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [NF-1:0]    cause,
  input  logic [NF-1:0]    enable,
  output logic             trap_req,
  output logic [VEC_W-1:0] trap_vec
);
  logic hit;
  assign hit = fire & (|(cause & enable));

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req <= 1'b0;
      trap_vec <= '0;
    end else begin
      trap_req <= hit;
      trap_vec <= hit ? TRAP_VEC : '0;
    end
  end

  // R5
  trap_vec_chk: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (trap_vec == TRAP_VEC));

  // R6
  trap_src_chk: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !trap_req);
endmodule

// File: rtl/fpx_mode_export.sv
module fpx_mode_export
  import fpx_pkg::*;
#(
  parameter logic [RM_W-1:0] RZ_CODE = 2'b01
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [RM_W-1:0] rm_in,
  input  logic            dn_in,
  output logic            rnd_to_zero,
  output logic            flush_den
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_to_zero <= 1'b0;
      flush_den   <= 1'b0;
    end else if (wr) begin
      rnd_to_zero <= (rm_in == RZ_CODE);
      flush_den   <= dn_in;
    end
  end

  // R10
  dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(flush_den));
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fpx_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                VEC_W    = 12,
  parameter logic [VEC_W-1:0]  TRAP_VEC = 12'h120,
  parameter logic [DATA_W-1:0] WR_MASK  = 32'h0007_FFFF,
  parameter logic [RM_W-1:0]   RZ_CODE  = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_done,
  input  logic [NF-1:0]     op_flags,
  input  logic              op_rsqrt,
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] csr_q,
  output logic              trap_req,
  output logic [VEC_W-1:0]  trap_vec,
  output logic              rnd_to_zero,
  output logic              flush_den
);
  localparam int CW = CAUSE_HI - CAUSE_LO + 1;

  initial begin
    if (DATA_W < MIN_W) $error("DATA_W too small for field layout");
  end

  logic [NF-1:0] new_cause;
  logic          op_fire;

  assign op_fire = op_done & ~sw_wr;

  fpx_cause_gen u_cause (
    .flags (op_flags),
    .rsqrt (op_rsqrt),
    .cause (new_cause)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q <= '0;
    end else if (sw_wr) begin
      csr_q <= sw_wdata & WR_MASK;
    end else if (op_done) begin
      csr_q[CAUSE_HI:CAUSE_LO] <= CW'(new_cause);
      csr_q[FLAG_HI:FLAG_LO]   <= csr_q[FLAG_HI:FLAG_LO] | new_cause;
    end
  end

  fpx_trap_unit #(.VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_trap (
    .clk      (clk),
    .rst      (rst),
    .fire     (op_fire),
    .cause    (new_cause),
    .enable   (csr_q[EN_HI:EN_LO]),
    .trap_req (trap_req),
    .trap_vec (trap_vec)
  );

  fpx_mode_export #(.RZ_CODE(RZ_CODE)) u_mode (
    .clk         (clk),
    .rst         (rst),
    .wr          (sw_wr),
    .rm_in       (sw_wdata[RM_LO+RM_W-1:RM_LO]),
    .dn_in       (sw_wdata[DN_BIT]),
    .rnd_to_zero (rnd_to_zero),
    .flush_den   (flush_den)
  );

  // R2
  err_cause_clr_chk: assert property (@(posedge clk) disable iff (rst)
    op_fire |=> !csr_q[CAUSE_HI]);

  // R3
  sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !sw_wr |=> ((csr_q[FLAG_HI:FLAG_LO] & $past(csr_q[FLAG_HI:FLAG_LO]))
                == $past(csr_q[FLAG_HI:FLAG_LO])));

  // R4
  enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sw_wr |=> $stable(csr_q[EN_HI:EN_LO]));

  // R8
  wr_mask_chk: assert property (@(posedge clk) disable iff (rst)
    sw_wr |=> (csr_q == ($past(sw_wdata) & WR_MASK)));

  // R9
  rz_decode_chk: assert property (@(posedge clk) disable iff (rst)
    sw_wr |=> (rnd_to_zero == ($past(sw_wdata[RM_LO+RM_W-1:RM_LO]) == RZ_CODE)));

  // R11
  wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    sw_wr |=> !trap_req);
endmodule

// File: tb/fpx_status_reg_test.sv
module fpx_status_reg_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_done;
  logic [4:0]  op_flags;
  logic        op_rsqrt;
  logic        sw_wr;
  logic [31:0] sw_wdata;
  logic [31:0] csr_q;
  logic        trap_req;
  logic [11:0] trap_vec;
  logic        rnd_to_zero;
  logic        flush_den;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_csr;

  always #4 clk = ~clk;

  fpx_status_reg uut (
    .clk(clk), .rst(rst), .op_done(op_done), .op_flags(op_flags),
    .op_rsqrt(op_rsqrt), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .csr_q(csr_q), .trap_req(trap_req), .trap_vec(trap_vec),
    .rnd_to_zero(rnd_to_zero), .flush_den(flush_den)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [31:0] d);
    @(negedge clk);
    sw_wr = 1'b1; sw_wdata = d;
    @(negedge clk);
    sw_wr = 1'b0;
    exp_csr = d & 32'h0007_FFFF;
  endtask

  // drives one operation; returns expected trap
  task automatic do_op(input logic [4:0] f, input logic rs, output logic exp_trap);
    logic [4:0] c;
    c = f;
    if (rs && f[4:1] == 4'b0) c[0] = 1'b1;
    @(negedge clk);
    op_done = 1'b1; op_flags = f; op_rsqrt = rs;
    @(negedge clk);
    op_done = 1'b0; op_flags = '0; op_rsqrt = 1'b0;
    exp_trap = |(c & exp_csr[11:7]);
    exp_csr[17:12] = {1'b0, c};
    exp_csr[6:2] = exp_csr[6:2] | c;
  endtask

  task automatic t_reset;
    check("R1 csr", csr_q, 32'h0);
    check("R1 trap", {31'b0, trap_req}, 32'h0);
    check("R1 vec", {20'b0, trap_vec}, 32'h0);
    check("R1 rz", {31'b0, rnd_to_zero}, 32'h0);
    check("R1 dn", {31'b0, flush_den}, 32'h0);
  endtask

  task automatic t_write;
    sw_write(32'hFFFF_FFFF);
    check("R8 mask", csr_q, 32'h0007_FFFF);
    check("R9 rm=11", {31'b0, rnd_to_zero}, 32'h0);
    check("R10 dn=1", {31'b0, flush_den}, 32'h1);
    sw_write(32'h0000_0001);
    check("R8 val", csr_q, 32'h1);
    check("R9 rm=01", {31'b0, rnd_to_zero}, 32'h1);
    check("R10 dn=0", {31'b0, flush_den}, 32'h0);
    sw_write(32'h0000_0002);
    check("R9 rm=10", {31'b0, rnd_to_zero}, 32'h0);
    sw_write(32'h0000_0000);
    check("R9 rm=00", {31'b0, rnd_to_zero}, 32'h0);
  endtask

  task automatic t_cause_sticky;
    logic tr;
    sw_write(32'h0002_0001);   // seed reserved cause bit 17, rm=01
    do_op(5'b10100, 1'b0, tr);
    check("R2 cause", csr_q, exp_csr);
    check("R2 bit17", {31'b0, csr_q[17]}, 32'h0);
    check("R6 no trap", {31'b0, trap_req}, {31'b0, tr});
    do_op(5'b00001, 1'b0, tr);
    check("R2 replace", {26'b0, csr_q[17:12]}, 32'h01);
    check("R3 sticky", {27'b0, csr_q[6:2]}, 32'h15);
    check("R4 rm kept", {30'b0, csr_q[1:0]}, 32'h1);
    do_op(5'b00000, 1'b0, tr);
    check("R3 never cleared", csr_q, exp_csr);
  endtask

  task automatic t_trap;
    logic tr;
    sw_write(32'h0004_0400);   // enable divzero, flush on
    do_op(5'b01000, 1'b0, tr);
    check("R5 trap", {31'b0, trap_req}, {31'b0, tr});
    check("R5 vec", {20'b0, trap_vec}, 32'h120);
    check("R4 csr", csr_q, exp_csr);
    @(negedge clk);
    check("R5 pulse", {31'b0, trap_req}, 32'h0);
    check("R5 vec idle", {20'b0, trap_vec}, 32'h0);
    do_op(5'b00010, 1'b0, tr);
    check("R6 sticky no trap", {31'b0, trap_req}, 32'h0);
    check("R4 en kept", {27'b0, csr_q[11:7]}, 32'h08);
    check("R10 dn kept", {31'b0, flush_den}, 32'h1);
  endtask

  task automatic t_rsqrt;
    logic tr;
    sw_write(32'h0000_0000);
    do_op(5'b00000, 1'b1, tr);
    check("R7 forced", {26'b0, csr_q[17:12]}, 32'h01);
    do_op(5'b10000, 1'b1, tr);
    check("R7 not forced", {26'b0, csr_q[17:12]}, 32'h10);
    check("R7 sticky", csr_q, exp_csr);
  endtask

  task automatic t_collide;
    sw_write(32'h0000_0F80);   // all enables
    @(negedge clk);
    sw_wr = 1'b1; sw_wdata = 32'h0000_0F83;
    op_done = 1'b1; op_flags = 5'b11111;
    @(negedge clk);
    sw_wr = 1'b0; op_done = 1'b0; op_flags = '0;
    check("R11 write wins", csr_q, 32'h0000_0F83);
    check("R11 no trap", {31'b0, trap_req}, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; op_done = 1'b0; op_flags = '0; op_rsqrt = 1'b0;
    sw_wr = 1'b0; sw_wdata = '0; exp_csr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_write;
    t_cause_sticky;
    t_trap;
    t_rsqrt;
    t_collide;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule